// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block is the interrupt controller of a small 8-bit processor core. It gathers event inputs from core and peripheral sources into flag bits and holds the global enable, the peripheral-group enable and one enable bit per source. Software reaches these through a four-entry register port. The core advances the block with an instruction-cycle strobe. Every decision and every latency is counted in those strobes, not in raw clocks.

When a pending, enabled flag meets a set global enable at a strobe, the block takes the interrupt. On that strobe it does four things. It asks the core to flush the prefetched instruction. It clears the global enable. It pushes the current program counter onto a 16-entry return stack. It copies the working context (accumulator, status, bank select, two pointers) into a single shadow set. One dead instruction cycle follows. After it, the block loads the program counter with the fixed vector.

A return request reverses the entry in one strobe. The saved address goes back to the program counter, the shadow context is presented for restore, and the global enable is set again. Any flag that is still set and enabled therefore re-enters at the next strobe.

Top module: `irqSeq`

## Requirements
- R1: After reset, every register in the map reads zero and no flush, load or restore pulse is driven.
- R2: A source's flag bit becomes set whenever its event arrives, whatever the global, group and source enables hold.
- R3: A request exists only if the global enable and the source enable are both set. Sources 0 to 2 are core sources and need nothing more. Sources 3 to 7 are peripheral sources and also need the group enable.
- R4: On the strobe that takes an interrupt, the block drives a one-clock flush pulse, clears the global enable, pushes the current PC and saves ctxIn into the shadow set. No PC load occurs on that strobe.
- R5: The strobe right after the flush produces no PC load. The next strobe loads the PC with 0x004.
- R6: While the global enable is clear, events only set flags. The first strobe after software sets the global enable takes any pending enabled flag.
- R7: Only a software write clears a flag, and a taken interrupt leaves its flag set. If an event and a write of zero reach a flag on the same clock, the flag ends up set.
- R8: A return request in idle pulses a PC load carrying the most recently pushed address, pulses ctxRestore with ctxOut equal to the saved context, and sets the global enable. Pushed addresses return in last-in, first-out order.
- R9: If a flag is still set and enabled when a return executes, the next strobe takes it again.
- R10: A synchronous source (sources 0 to 6) sets its flag on each clock edge on which its input is high. A strobe takes the interrupt only if the flag was set on an edge before that strobe. An event in the strobe's own clock is therefore taken one strobe later, which gives an entry latency of 3 or 4 strobes up to the vector load.
- R11: The asynchronous source (source 7) passes through a two-flop synchronizer with rising-edge detection. Its flag sets on the third clock edge after the input rises. A level that stays high does not set the flag again after software clears it.
- R12: The return stack holds 16 entries. A 17th push without a pop overwrites the oldest entry and sets a sticky overflow flag. After such a wrap the next pop still returns the latest address.
- R13: A pop from an empty stack sets a sticky underflow flag.
- R14: The register map is: address 0 holds the global enable in bit 0 and the group enable in bit 1. Address 1 holds the flags. Address 2 holds the source enables. Address 3 is read-only, with stack overflow in bit 0 and underflow in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycStb | input | 1 | Instruction-cycle strobe, one clock wide |
| evtIn | input | 8 | Source event inputs, bit 7 asynchronous |
| regWr | input | 1 | Register write enable |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| pcIn | input | 11 | Current program counter |
| retReq | input | 1 | Return-from-interrupt request, sampled on a strobe |
| ctxIn | input | 53 | Live context {ptr1, ptr0, bank, status, acc}, acc in the low byte |
| flushStb | output | 1 | Flush the prefetched instruction |
| pcLoad | output | 1 | Load pcLoadVal into the PC |
| pcLoadVal | output | 11 | Vector or return address |
| ctxRestore | output | 1 | Restore ctxOut into the live registers |
| ctxOut | output | 53 | Shadow context |
| stackOvf | output | 1 | Sticky return-stack overflow |
| stackUnf | output | 1 | Sticky return-stack underflow |

## Verification
The hardest condition to reach from the ports is a return-stack overflow. Nested entry cannot happen, so each push needs a complete take, dead cycle and vector load, and then software must set the global enable again while the flag stays pending. The bench repeats that loop seventeen times with a different PC value each time, then returns once to confirm that the newest address survived the wrap. The asynchronous latency corners are reached by raising the asynchronous input a chosen number of clocks after a strobe. This places the synchronizer's flag-set edge either just before a strobe or exactly on it.

// File: rtl/irqSeqPkg.sv
package irqSeqPkg;

  localparam int ACC_W  = 8;
  localparam int STAT_W = 8;
  localparam int BANK_W = 5;
  localparam int PTR_W  = 16;

  typedef struct packed {
    logic [PTR_W-1:0]  ptr1;
    logic [PTR_W-1:0]  ptr0;
    logic [BANK_W-1:0] bank;
    logic [STAT_W-1:0] status;
    logic [ACC_W-1:0]  acc;
  } ctx_t;

  localparam int CTX_W = $bits(ctx_t);

  // strobes from the sequencer to the datapath, each valid for one clock
  typedef struct packed {
    logic take;
    logic vecLoad;
    logic ret;
  } seqCtl_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DEAD = 2'd1,
    SEQ_VEC  = 2'd2
  } seqState_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_EN   = 2'd2;
  localparam logic [1:0] ADDR_STK  = 2'd3;

endpackage

// File: rtl/irqSources.sv
module irqSources import irqSeqPkg::*; #(
  parameter int NSRC = 8,
  parameter int NUM_CORE = 3,
  parameter int REG_W = 8,
  parameter logic [NSRC-1:0] ASYNC_MASK = 8'h80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  evtIn,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  input  logic             takeStb,
  input  logic             retStb,
  output logic [NSRC-1:0]  flags,
  output logic [NSRC-1:0]  enables,
  output logic             gie,
  output logic             grpEn,
  output logic             irqReq
);

  localparam logic [NSRC-1:0] CORE_MASK = NSRC'((1 << NUM_CORE) - 1);

  logic [NSRC-1:0] setEvt;
  logic [NSRC-1:0] reqVec;

  for (genvar i = 0; i < NSRC; i++) begin : gSrc
    if (ASYNC_MASK[i]) begin : gAsync
      logic s1, s2, s3;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          s1 <= 1'b0;
          s2 <= 1'b0;
          s3 <= 1'b0;
        end else begin
          s1 <= evtIn[i];
          s2 <= s1;
          s3 <= s2;
        end
      end
      assign setEvt[i] = s2 & ~s3;
    end else begin : gSync
      assign setEvt[i] = evtIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '0;
    end else if (regWr && regAddr == ADDR_FLAG) begin
      flags <= regWdata[NSRC-1:0] | setEvt;
    end else begin
      flags <= flags | setEvt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enables <= '0;
    end else if (regWr && regAddr == ADDR_EN) begin
      enables <= regWdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gie   <= 1'b0;
      grpEn <= 1'b0;
    end else begin
      if (takeStb) begin
        gie <= 1'b0;
      end else if (retStb) begin
        gie <= 1'b1;
      end else if (regWr && regAddr == ADDR_CTRL) begin
        gie <= regWdata[0];
      end
      if (regWr && regAddr == ADDR_CTRL) begin
        grpEn <= regWdata[1];
      end
    end
  end

  assign reqVec = flags & enables & (CORE_MASK | {NSRC{grpEn}});
  assign irqReq = gie & (|reqVec);

  AST_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (setEvt != '0) |=> ((flags & $past(setEvt)) == $past(setEvt))); // R2
  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    takeStb |-> gie); // R3
  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    takeStb |=> !gie); // R4
  AST_RET_SETS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    retStb |=> gie); // R8

endmodule

// File: rtl/irqCtrl.sv
module irqCtrl import irqSeqPkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cycStb,
  input  logic    irqReq,
  input  logic    retReq,
  output seqCtl_t ctl
);

  seqState_t state;

  always_comb begin
    ctl = '0;
    if (cycStb) begin
      unique case (state)
        SEQ_IDLE: begin
          if (retReq) ctl.ret = 1'b1;
          else if (irqReq) ctl.take = 1'b1;
        end
        SEQ_VEC: ctl.vecLoad = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
    end else if (cycStb) begin
      unique case (state)
        SEQ_IDLE: if (!retReq && irqReq) state <= SEQ_DEAD;
        SEQ_DEAD: state <= SEQ_VEC;
        SEQ_VEC:  state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  AST_NO_RET_IN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take || ctl.vecLoad) |-> !ctl.ret); // R8

endmodule

// File: rtl/irqDatapath.sv
module irqDatapath import irqSeqPkg::*; #(
  parameter int PC_W = 11,
  parameter int STACK_DEPTH = 16,
  parameter logic [PC_W-1:0] VECTOR_ADDR = 'h4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqCtl_t         ctl,
  input  logic [PC_W-1:0] pcIn,
  input  ctx_t            ctxIn,
  output logic            flushStb,
  output logic            pcLoad,
  output logic [PC_W-1:0] pcLoadVal,
  output logic            ctxRestore,
  output ctx_t            ctxOut,
  output logic            stackOvf,
  output logic            stackUnf
);

  localparam int PTR_BITS = $clog2(STACK_DEPTH);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam logic [PTR_BITS-1:0] LAST_IDX = PTR_BITS'(STACK_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(STACK_DEPTH);

  logic [PC_W-1:0]     stackMem [STACK_DEPTH];
  logic [PTR_BITS-1:0] wrPtr, ptrInc, ptrDec;
  logic [CNT_W-1:0]    depthCnt;
  ctx_t                shadowCtx;

  always_comb begin
    ptrInc = (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
    ptrDec = (wrPtr == '0) ? LAST_IDX : wrPtr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.take) stackMem[wrPtr] <= pcIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      depthCnt <= '0;
      stackOvf <= 1'b0;
      stackUnf <= 1'b0;
    end else if (ctl.take) begin
      wrPtr <= ptrInc;
      if (depthCnt == FULL_CNT) stackOvf <= 1'b1;
      else depthCnt <= depthCnt + 1'b1;
    end else if (ctl.ret) begin
      wrPtr <= ptrDec;
      if (depthCnt == '0) stackUnf <= 1'b1;
      else depthCnt <= depthCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCtx <= '0;
    end else if (ctl.take) begin
      shadowCtx <= ctxIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushStb   <= 1'b0;
      pcLoad     <= 1'b0;
      ctxRestore <= 1'b0;
      pcLoadVal  <= '0;
    end else begin
      flushStb   <= ctl.take;
      pcLoad     <= ctl.vecLoad | ctl.ret;
      ctxRestore <= ctl.ret;
      if (ctl.ret) pcLoadVal <= stackMem[ptrDec];
      else if (ctl.vecLoad) pcLoadVal <= VECTOR_ADDR;
    end
  end

  assign ctxOut = shadowCtx;

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flushStb, pcLoad})); // R4
  AST_VECTOR_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && !ctxRestore) |-> pcLoadVal == VECTOR_ADDR); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stackOvf |=> stackOvf); // R12
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stackUnf |=> stackUnf); // R13

endmodule

// File: rtl/irqSeq.sv
module irqSeq import irqSeqPkg::*; #(
  parameter int NSRC = 8,
  parameter int NUM_CORE = 3,
  parameter int REG_W = 8,
  parameter logic [NSRC-1:0] ASYNC_MASK = 8'h80,
  parameter int PC_W = 11,
  parameter int STACK_DEPTH = 16,
  parameter logic [PC_W-1:0] VECTOR_ADDR = 'h4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycStb,
  input  logic [NSRC-1:0]  evtIn,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic [PC_W-1:0]  pcIn,
  input  logic             retReq,
  input  logic [CTX_W-1:0] ctxIn,
  output logic             flushStb,
  output logic             pcLoad,
  output logic [PC_W-1:0]  pcLoadVal,
  output logic             ctxRestore,
  output logic [CTX_W-1:0] ctxOut,
  output logic             stackOvf,
  output logic             stackUnf
);

  seqCtl_t         ctl;
  logic [NSRC-1:0] flags, enables;
  logic            gie, grpEn, irqReq;
  ctx_t            ctxSave, ctxShadow;

  assign ctxSave = ctx_t'(ctxIn);
  assign ctxOut  = ctxShadow;

  irqSources #(
    .NSRC(NSRC), .NUM_CORE(NUM_CORE), .REG_W(REG_W), .ASYNC_MASK(ASYNC_MASK)
  ) uSources (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .takeStb(ctl.take), .retStb(ctl.ret),
    .flags(flags), .enables(enables), .gie(gie), .grpEn(grpEn), .irqReq(irqReq)
  );

  irqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cycStb(cycStb), .irqReq(irqReq),
    .retReq(retReq), .ctl(ctl)
  );

  irqDatapath #(
    .PC_W(PC_W), .STACK_DEPTH(STACK_DEPTH), .VECTOR_ADDR(VECTOR_ADDR)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pcIn(pcIn), .ctxIn(ctxSave),
    .flushStb(flushStb), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal),
    .ctxRestore(ctxRestore), .ctxOut(ctxShadow),
    .stackOvf(stackOvf), .stackUnf(stackUnf)
  );

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdata[0] = gie;
        regRdata[1] = grpEn;
      end
      ADDR_FLAG: regRdata[NSRC-1:0] = flags;
      ADDR_EN:   regRdata[NSRC-1:0] = enables;
      default: begin
        regRdata[0] = stackOvf;
        regRdata[1] = stackUnf;
      end
    endcase
  end

  AST_FLUSH_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    flushStb |-> !gie); // R4

endmodule

// File: tb/tb_irqSeq.sv
module tb_irqSeq;
  import irqSeqPkg::*;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cycStb = 1'b0;
  logic [6:0]       syncPulse = '0;
  logic             asyncLvl = 1'b0;
  logic [7:0]       evtIn;
  logic             regWr = 1'b0;
  logic [1:0]       regAddr = '0;
  logic [7:0]       regWdata = '0;
  logic [7:0]       regRdata;
  logic [10:0]      pcIn = '0;
  logic             retReq = 1'b0;
  logic [CTX_W-1:0] ctxIn = '0;
  logic             flushStb, pcLoad, ctxRestore, stackOvf, stackUnf;
  logic [10:0]      pcLoadVal;
  logic [CTX_W-1:0] ctxOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic             sFlush, sLoad, sRest;
  logic [10:0]      sVal;
  logic [CTX_W-1:0] sCtx;
  logic [7:0]       rd;

  assign evtIn = {asyncLvl, syncPulse};

  always #10 clk = ~clk;

  irqSeq dut (
    .clk(clk), .rstN(rstN), .cycStb(cycStb), .evtIn(evtIn), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .pcIn(pcIn),
    .retReq(retReq), .ctxIn(ctxIn), .flushStb(flushStb), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal), .ctxRestore(ctxRestore), .ctxOut(ctxOut),
    .stackOvf(stackOvf), .stackUnf(stackUnf)
  );

  typedef struct packed {
    logic       gie;
    logic       grp;
    logic [7:0] en;
    logic [7:0] evt;
    logic       expTake;
  } vec_t;

  localparam vec_t VEC_TBL [8] = '{
    '{1'b1, 1'b0, 8'h01, 8'h01, 1'b1},
    '{1'b0, 1'b1, 8'h7f, 8'h01, 1'b0},
    '{1'b1, 1'b0, 8'h08, 8'h08, 1'b0},
    '{1'b1, 1'b1, 8'h08, 8'h08, 1'b1},
    '{1'b1, 1'b1, 8'h77, 8'h08, 1'b0},
    '{1'b1, 1'b1, 8'h02, 8'h01, 1'b0},
    '{1'b1, 1'b0, 8'h06, 8'h04, 1'b1},
    '{1'b1, 1'b1, 8'h40, 8'h40, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic ret);
    cycStb = 1'b1;
    retReq = ret;
    @(posedge clk);
    @(negedge clk);
    cycStb = 1'b0;
    retReq = 1'b0;
    syncPulse = '0;
    sFlush = flushStb;
    sLoad = pcLoad;
    sVal = pcLoadVal;
    sRest = ctxRestore;
    sCtx = ctxOut;
  endtask

  task automatic instr(input logic ret);
    strobe(ret);
    idle(3);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    regWr = 1'b1;
    regAddr = a;
    regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a);
    regAddr = a;
    #1;
    rd = regRdata;
  endtask

  task automatic pulse(input logic [6:0] m);
    syncPulse = m;
    @(negedge clk);
    syncPulse = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    asyncLvl = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // R1 and R14: reset state of the register map and outputs
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a));
      chk("R1 reg reset", rd, 0);
    end
    chk("R1 outputs idle", {flushStb, pcLoad, ctxRestore}, 0);

    // table: enable gating (R2, R3)
    for (int v = 0; v < 8; v++) begin
      wreg(ADDR_CTRL, 8'h00);
      wreg(ADDR_FLAG, 8'h00);
      wreg(ADDR_EN, VEC_TBL[v].en);
      pulse(VEC_TBL[v].evt[6:0]);
      rreg(ADDR_FLAG);
      chk("R2 flag latched", rd, VEC_TBL[v].evt);
      wreg(ADDR_CTRL, {6'b0, VEC_TBL[v].grp, VEC_TBL[v].gie});
      instr(1'b0);
      chk("R3 take gating", sFlush, VEC_TBL[v].expTake);
      wreg(ADDR_FLAG, 8'h00);
      instr(1'b0);
      instr(1'b0);
    end

    // entry and return (R4, R5, R8)
    doReset();
    wreg(ADDR_EN, 8'h01);
    pcIn = 11'h123;
    ctxIn = 53'h1A_BCDE_F012_3456;
    pulse(7'h01);
    wreg(ADDR_CTRL, 8'h01);
    instr(1'b0);
    chk("R4 flush on take", sFlush, 1);
    chk("R4 no load on take", sLoad, 0);
    rreg(ADDR_CTRL);
    chk("R4 global enable cleared", rd, 0);
    ctxIn = 53'h0;
    pcIn = 11'h555;
    instr(1'b0);
    chk("R5 dead cycle no load", {sLoad, sFlush}, 0);
    instr(1'b0);
    chk("R5 vector load", sLoad, 1);
    chk("R5 vector value", sVal, 11'h004);
    rreg(ADDR_FLAG);
    chk("R7 flag kept after take", rd, 8'h01);
    wreg(ADDR_FLAG, 8'h00);
    instr(1'b1);
    chk("R8 return load", {sLoad, sRest}, 2'b11);
    chk("R8 return address", sVal, 11'h123);
    chk("R8 restored context", sCtx, 53'h1A_BCDE_F012_3456);
    rreg(ADDR_CTRL);
    chk("R8 global enable set", rd, 8'h01);
    instr(1'b0);
    chk("R8 no re-entry when cleared", sFlush, 0);

    // re-entry (R9)
    pulse(7'h01);
    instr(1'b0);
    chk("R9 take", sFlush, 1);
    instr(1'b0);
    instr(1'b0);
    instr(1'b1);
    chk("R9 return", sLoad, 1);
    instr(1'b0);
    chk("R9 re-entry", sFlush, 1);
    instr(1'b0);
    instr(1'b0);
    wreg(ADDR_FLAG, 8'h00);

    // pending while disabled (R6, R7)
    wreg(ADDR_CTRL, 8'h00);
    pulse(7'h01);
    instr(1'b0);
    chk("R6 no take while disabled", sFlush, 0);
    instr(1'b0);
    chk("R6 still no take", sFlush, 0);
    rreg(ADDR_FLAG);
    chk("R7 flag held", rd, 8'h01);
    wreg(ADDR_CTRL, 8'h01);
    instr(1'b0);
    chk("R6 taken once enabled", sFlush, 1);
    instr(1'b0);
    instr(1'b0);
    regWr = 1'b1; regAddr = ADDR_FLAG; regWdata = 8'h00; syncPulse = 7'h02;
    @(negedge clk);
    regWr = 1'b0; syncPulse = '0;
    rreg(ADDR_FLAG);
    chk("R7 event beats clearing write", rd, 8'h02);

    // synchronous latency (R10)
    doReset();
    wreg(ADDR_EN, 8'h01);
    wreg(ADDR_CTRL, 8'h01);
    syncPulse = 7'h01;
    strobe(1'b0);
    chk("R10 event in strobe clock not taken", sFlush, 0);
    idle(3);
    instr(1'b0);
    chk("R10 taken next strobe", sFlush, 1);
    instr(1'b0);
    instr(1'b0);
    chk("R10 vector after 2 more strobes", sLoad, 1);

    // asynchronous source (R11)
    doReset();
    wreg(ADDR_EN, 8'h80);
    wreg(ADDR_CTRL, 8'h03);
    strobe(1'b0);
    asyncLvl = 1'b1;
    idle(3);
    instr(1'b0);
    chk("R11 async flag in time", sFlush, 1);
    instr(1'b0);
    instr(1'b0);
    wreg(ADDR_FLAG, 8'h00);
    wreg(ADDR_CTRL, 8'h03);
    instr(1'b0);
    instr(1'b0);
    chk("R11 held level no new flag", sFlush, 0);
    rreg(ADDR_FLAG);
    chk("R11 flag stays clear", rd, 0);
    asyncLvl = 1'b0;
    idle(4);
    strobe(1'b0);
    idle(1);
    asyncLvl = 1'b1;
    idle(2);
    strobe(1'b0);
    chk("R11 flag set on strobe edge not taken", sFlush, 0);
    idle(3);
    instr(1'b0);
    chk("R11 taken one strobe later", sFlush, 1);
    instr(1'b0);
    instr(1'b0);

    // LIFO order (R8)
    doReset();
    wreg(ADDR_EN, 8'h01);
    wreg(ADDR_CTRL, 8'h01);
    pcIn = 11'h0AA;
    pulse(7'h01);
    instr(1'b0); instr(1'b0); instr(1'b0);
    pcIn = 11'h0BB;
    wreg(ADDR_CTRL, 8'h01);
    instr(1'b0); instr(1'b0); instr(1'b0);
    wreg(ADDR_FLAG, 8'h00);
    instr(1'b1);
    chk("R8 LIFO first pop", sVal, 11'h0BB);
    instr(1'b1);
    chk("R8 LIFO second pop", sVal, 11'h0AA);

    // stack overflow (R12)
    doReset();
    wreg(ADDR_EN, 8'h01);
    wreg(ADDR_CTRL, 8'h01);
    pulse(7'h01);
    for (int i = 0; i < 16; i++) begin
      pcIn = 11'(11'h100 + i);
      instr(1'b0); instr(1'b0); instr(1'b0);
      wreg(ADDR_CTRL, 8'h01);
    end
    rreg(ADDR_STK);
    chk("R12 no overflow at 16", rd, 0);
    pcIn = 11'h110;
    instr(1'b0); instr(1'b0); instr(1'b0);
    chk("R12 overflow output", stackOvf, 1);
    rreg(ADDR_STK);
    chk("R12 overflow bit", rd, 8'h01);
    wreg(ADDR_FLAG, 8'h00);
    instr(1'b1);
    chk("R12 newest survives wrap", sVal, 11'h110);
    chk("R12 overflow sticky", stackOvf, 1);

    // stack underflow (R13)
    doReset();
    instr(1'b1);
    chk("R13 pop still loads", sLoad, 1);
    rreg(ADDR_STK);
    chk("R13 underflow bit", rd, 8'h02);
    instr(1'b0);
    chk("R13 underflow sticky", stackUnf, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule